// File: doc/BRIEF.md
# Dual-Processor Bus Owner Switch

This controller sits beside two instruction-compatible processors that share a single address and data bus. Only one of them may own that bus at any moment. Software picks the owner, and the source of the boot firmware, through a small indexed register file. A write to the index port chooses a register. Reads and writes on the data port then reach the register that was chosen. The index stays in place after each data access, so a block-output instruction can write the mode register twice in a row.

The mode register (index 6) holds two bits: which processor owns the bus, and whether the firmware comes from ROM or from its copy in DRAM. When a write flips the processor bit, a hand-over begins. The outgoing processor is told to hold and keeps its grant until it reports the end of its current bus cycle. Then both grants stay low for a configurable number of idle cycles, and after that the incoming processor is granted. The controller saves no processor state. A held processor simply freezes and later resumes where it stopped. The fast processor is kept in reset until it is granted the bus for the first time, so it starts fetching from address 0.

Top module: `cpu_swap_ctrl`

## Requirements
- R1: After reset the compatible processor is granted (grant_a=1, hold_a=0), the fast processor is held and not granted (grant_b=0, hold_b=1), rom_sel=1, and register 6 reads 0x60.
- R2: A write to port 0xE4 loads the register index. With the address at port 0xE5, io_rdata shows the indexed register in the same cycle. Any index other than 6 reads 0x00 and ignores writes, and any other address reads 0x00.
- R3: Register 6 bit 5 picks the processor (1 = compatible A, 0 = fast B) and bit 6 picks the firmware source (1 = ROM). rom_sel follows bit 6 from the cycle after the write.
- R4: A write that changes bit 5 raises hold on the outgoing processor in the next cycle. Its grant drops only after an edge at which its cyc_end input was 1. Both grants then stay low for GAP_CYC cycles, and after that the incoming processor gets grant=1 and hold=0.
- R5: grant_a and grant_b are never 1 together, and a grant never rises in the cycle right after the other grant was 1.
- R6: From the write that starts a hand-over until the new grant, writes to register 6 change nothing. The index persists across consecutive data-port writes.
- R7: core_rst_b is 1 from reset until the fast processor is first granted, and stays 0 from then on.
- R8: A register 6 write that keeps bit 5 unchanged starts no hand-over and updates only the firmware source bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| cyc_end_a | input | 1 | Compatible processor is at a bus-cycle boundary |
| cyc_end_b | input | 1 | Fast processor is at a bus-cycle boundary |
| hold_a | output | 1 | Freeze request to the compatible processor |
| hold_b | output | 1 | Freeze request to the fast processor |
| grant_a | output | 1 | Compatible processor may drive the bus |
| grant_b | output | 1 | Fast processor may drive the bus |
| core_rst_b | output | 1 | Reset to the fast processor until its first grant |
| rom_sel | output | 1 | 1 = firmware from ROM, 0 = from DRAM copy |

## Verification
Read data is combinational, so it is compared in the same cycle the address is presented. rom_sel, the index and the hold outputs change one edge after a write. A grant drops one edge after the outgoing processor's boundary is sampled, and the new grant arrives GAP_CYC edges later. The bench drives inputs one nanosecond after the rising edge and compares every output against a behavioural model at the falling edge, so each result is checked in the cycle it is due. It also waits for the new grant before running the targeted checks for ignored writes and for the unchanged processor bit.

// File: rtl/cpu_swap_ctrl.sv
module cpu_swap_ctrl #(
  parameter logic [7:0] IDX_PORT  = 8'hE4,
  parameter logic [7:0] DATA_PORT = 8'hE5,
  parameter logic [7:0] MODE_IDX  = 8'd6,
  parameter int         CPU_BIT   = 5,
  parameter int         ROM_BIT   = 6,
  parameter int         GAP_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic [7:0] io_addr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  input  logic       cyc_end_a,
  input  logic       cyc_end_b,
  output logic       hold_a,
  output logic       hold_b,
  output logic       grant_a,
  output logic       grant_b,
  output logic       core_rst_b,
  output logic       rom_sel
);
  localparam int CW = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {RUN, DRAIN, GAP} phase_t;

  phase_t        phase;
  logic [7:0]    idx_q;
  logic          cpu_q, rom_q, owner_q, fresh_q;
  logic [CW-1:0] cnt_q;

  wire wr_idx   = io_wr && io_addr == IDX_PORT;
  wire wr_mode  = io_wr && io_addr == DATA_PORT && idx_q == MODE_IDX && phase == RUN;
  wire swap_req = wr_mode && io_wdata[CPU_BIT] != cpu_q;
  wire owner_end = owner_q ? cyc_end_a : cyc_end_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= RUN;
      idx_q   <= '0;
      cpu_q   <= 1'b1;
      rom_q   <= 1'b1;
      owner_q <= 1'b1;
      fresh_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      if (wr_idx) idx_q <= io_wdata;
      if (wr_mode) begin
        rom_q <= io_wdata[ROM_BIT];
        cpu_q <= io_wdata[CPU_BIT];
      end
      unique case (phase)
        RUN:   if (swap_req) phase <= DRAIN;
        DRAIN: if (owner_end) begin
                 phase <= GAP;
                 cnt_q <= CW'(GAP_CYC - 1);
               end
        GAP:   if (cnt_q == '0) begin
                 phase   <= RUN;
                 owner_q <= cpu_q;
                 if (!cpu_q) fresh_q <= 1'b0;
               end else cnt_q <= cnt_q - 1'b1;
        default: phase <= RUN;
      endcase
    end
  end

  logic [7:0] mode_rd;
  always_comb begin
    mode_rd = '0;
    mode_rd[CPU_BIT] = cpu_q;
    mode_rd[ROM_BIT] = rom_q;
  end

  assign io_rdata   = (io_addr == DATA_PORT && idx_q == MODE_IDX) ? mode_rd : 8'h00;
  assign grant_a    = owner_q && phase != GAP;
  assign grant_b    = !owner_q && phase != GAP;
  assign hold_a     = !(owner_q && phase == RUN);
  assign hold_b     = !(!owner_q && phase == RUN);
  assign core_rst_b = fresh_q;
  assign rom_sel    = rom_q;

  p_excl_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_a && grant_b));
  p_gap_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_a) |-> !$past(grant_b));
  p_gap_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_b) |-> !$past(grant_a));
  p_boundary_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_a) |-> $past(cyc_end_a));
  p_boundary_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_b) |-> $past(cyc_end_b));
  p_rom_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!grant_a && !grant_b) && !grant_a && !grant_b) |-> $stable(rom_sel));
  p_fast_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_b |-> !grant_b);
  p_no_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(core_rst_b));
endmodule

// File: tb/cpu_swap_ctrl_test.sv
`timescale 1ns/1ps
module cpu_swap_ctrl_test;
  localparam int GAP = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic io_wr = 1'b0;
  logic [7:0] io_addr = 8'h00, io_wdata = 8'h00;
  logic cyc_end_a = 1'b0, cyc_end_b = 1'b0;
  logic [7:0] io_rdata;
  logic hold_a, hold_b, grant_a, grant_b, core_rst_b, rom_sel;

  cpu_swap_ctrl #(.GAP_CYC(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cyc_end_a(cyc_end_a),
    .cyc_end_b(cyc_end_b), .hold_a(hold_a), .hold_b(hold_b),
    .grant_a(grant_a), .grant_b(grant_b), .core_rst_b(core_rst_b),
    .rom_sel(rom_sel));

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_idx = 0, m_cpu = 1, m_rom = 1, m_owner = 1, m_fresh = 1, m_phase = 0, m_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_cpu = 1; m_rom = 1; m_owner = 1; m_fresh = 1; m_phase = 0; m_cnt = 0;
    end else begin
      bit dw;
      dw = io_wr && io_addr == 8'hE5 && m_idx == 6;
      if (io_wr && io_addr == 8'hE4) m_idx = io_wdata;
      if (m_phase == 0) begin
        if (dw) begin
          m_rom = io_wdata[6];
          if (io_wdata[5] != m_cpu) begin m_cpu = io_wdata[5]; m_phase = 1; end
        end
      end else if (m_phase == 1) begin
        if (m_owner ? cyc_end_a : cyc_end_b) begin m_phase = 2; m_cnt = GAP - 1; end
      end else begin
        if (m_cnt == 0) begin
          m_phase = 0; m_owner = m_cpu;
          if (m_cpu == 0) m_fresh = 0;
        end else m_cnt--;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    int exp_rd;
    exp_rd = (io_addr == 8'hE5 && m_idx == 6) ? (m_rom << 6) | (m_cpu << 5) : 0;
    chk("R2 rdata", io_rdata, exp_rd);
    chk("R3 rom_sel", rom_sel, m_rom);
    chk("R4 grant_a", grant_a, m_owner == 1 && m_phase != 2);
    chk("R4 grant_b", grant_b, m_owner == 0 && m_phase != 2);
    chk("R4 hold_a", hold_a, !(m_owner == 1 && m_phase == 0));
    chk("R4 hold_b", hold_b, !(m_owner == 0 && m_phase == 0));
    chk("R7 core_rst_b", core_rst_b, m_fresh);
    chk("R5 exclusive", grant_a & grant_b, 0);
  end

  initial begin : bounds
    int k = 0;
    forever begin
      @(posedge clk); #1;
      k++;
      cyc_end_a = (k % 3 == 0);
      cyc_end_b = (k % 4 == 1);
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    io_wr = 1'b1; io_addr = a; io_wdata = d;
  endtask

  task automatic idle(logic [7:0] a);
    @(posedge clk); #1;
    io_wr = 1'b0; io_addr = a;
  endtask

  task automatic wait_grant(bit b);
    while ((b ? grant_b : grant_a) !== 1'b1) begin @(negedge clk); #0.5; end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #0.5;
    // R1 reset state
    chk("R1 grant_a", grant_a, 1); chk("R1 grant_b", grant_b, 0);
    chk("R1 hold_a", hold_a, 0);   chk("R1 hold_b", hold_b, 1);
    chk("R1 rom_sel", rom_sel, 1); chk("R1 core_rst_b", core_rst_b, 1);
    wr(8'hE4, 8'd6);
    idle(8'hE5);
    @(negedge clk); #0.5;
    chk("R1 reg6", io_rdata, 8'h60);
    // R6: block output of 0x40 then 0x60; the second write is ignored
    wr(8'hE5, 8'h40);
    wr(8'hE5, 8'h60);
    idle(8'hE5);
    wait_grant(1);
    chk("R6 reg6 after ignored write", io_rdata, 8'h40);
    chk("R7 core_rst_b released", core_rst_b, 0);
    // R8: same processor, DRAM source
    wr(8'hE5, 8'h00);
    idle(8'hE5);
    @(negedge clk); #0.5;
    chk("R8 rom_sel", rom_sel, 0);
    chk("R8 no handover", {hold_b, grant_b}, 2'b01);
    repeat (4) @(posedge clk);
    chk("R8 still owner", grant_b, 1);
    // back to compatible processor
    wr(8'hE5, 8'h60);
    idle(8'hE5);
    wait_grant(0);
    chk("R4 back to a", grant_b, 0);
    // R2 other index
    wr(8'hE4, 8'd3);
    wr(8'hE5, 8'h55);
    idle(8'hE5);
    @(negedge clk); #0.5;
    chk("R2 other idx", io_rdata, 8'h00);
    idle(8'hE4);
    @(negedge clk); #0.5;
    chk("R2 index port reads 0", io_rdata, 8'h00);
    wr(8'hE4, 8'd6);
    idle(8'hE5);
    @(negedge clk); #0.5;
    chk("R2 reg6 untouched", io_rdata, 8'h60);
    // second switch to fast core: reset stays low (R7)
    wr(8'hE5, 8'h00);
    idle(8'hE5);
    wait_grant(1);
    chk("R7 no re-reset", core_rst_b, 0);
    chk("R3 DRAM select", rom_sel, 0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule